// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is the external-bus master for an 8051-style core. It shares two byte-wide ports between two cycle types. The low port carries address and data on the same pins. The high port carries the upper address. A code fetch presents a 16-bit program address and reads one instruction byte under the program-store strobe. A data access presents a 24-bit pointer, made of a page byte, a high byte and a low byte, and either reads one byte under the read strobe or writes one byte under the write strobe.

Every cycle runs through the same fixed phases:

1. Address: the address-latch pulse is high.
2. Hold: the pulse has fallen and the address is still driven.
3. Strobe: the selected strobe is active.
4. Release: the strobe is inactive again.

The length of each phase is a parameter, counted in clocks.

In a data cycle, the high port drives the page byte while the latch pulse is high, so a second external latch can capture bits 23..16. For the rest of the cycle it drives the high byte. If a board fits no such latch, the page byte is simply lost. The bus then behaves as a plain 64 KB data space, and no mode setting is involved.

The core side has two request lines. A fetch request takes priority over a data request. Only one cycle is in flight at a time. Completion is reported by a one-clock done pulse, and the returned byte is presented alongside it.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, and whenever no cycle is in progress, ale is low, psen_n, rd_n and wr_n are high, and both port output enables are low.
- R2: A cycle starts on the first clock edge at which the controller is idle, is not in a done cycle, and sees a request. For ADDR_CLKS clocks, ale is high and the low port drives address bits 7..0. For the next HOLD_CLKS clocks, ale is low and the low port still drives the same byte.
- R3: In a code fetch, the high port drives program address bits 15..8 from the address phase through the release phase. After the hold phase, psen_n is low for STRB_CLKS clocks with the low port released. The byte on p0_in at the last strobe clock is returned on rdata.
- R4: In a data cycle, the high port drives pointer bits 23..16 while ale is high. From the hold phase to the end of the release phase it drives bits 15..8.
- R5: In a data write (data_we high), wr_n is low for STRB_CLKS clocks after the hold phase. The low port drives the write byte from the first strobe clock through the last release clock.
- R6: In a data read (data_we low), rd_n is low for STRB_CLKS clocks after the hold phase, with the low port released. The byte on p0_in at the last strobe clock is returned on rdata.
- R7: When fetch_req and data_req are both high at an accepting edge, the fetch is run first. The data request is served afterwards.
- R8: busy is high from the cycle after acceptance until the last release clock. The request and its address and data are captured at acceptance, and later changes on the request inputs have no effect on that cycle. No request is accepted while busy or during the done cycle.
- R9: In the clock after the last release clock, exactly one of fetch_done or data_done is high, for one clock. fetch_done marks a code fetch, and data_done marks a read or write.
- R10: At most one of psen_n, rd_n and wr_n is low at any time. p0_oe is never high while psen_n or rd_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req | input | 1 | Code fetch request, held until fetch_done |
| fetch_addr | input | 16 | Program address |
| data_req | input | 1 | Data access request, held until data_done |
| data_we | input | 1 | 1 = write, 0 = read |
| data_addr | input | 24 | Data pointer {page, high, low} |
| data_wdata | input | 8 | Write byte |
| busy | output | 1 | Cycle in progress |
| fetch_done | output | 1 | One-clock completion of a fetch |
| data_done | output | 1 | One-clock completion of a data access |
| rdata | output | 8 | Byte returned by the last fetch or read |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low port output value |
| p0_oe | output | 1 | Low port output enable |
| p0_in | input | 8 | Low port input value |
| p2_out | output | 8 | High port output value |
| p2_oe | output | 1 | High port output enable |

## Verification
The hardest situation to reach from the ports is contention: a second request arriving while a cycle is in flight, or both requests rising on the same edge. The second request must wait through the done cycle without disturbing the captured address. The stimulus raises a data request two clocks into a fetch and changes the fetch address at the same moment. It also raises both requests together. The reference model's accept rule then predicts the idle gap and the fetch-first order clock by clock. A write followed by reads at two pointers that differ only in the page byte shows, through a bench memory stub with its own page latch, that the page byte reaches the bus during the latch pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int XB_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_STRB = 3'd3,
    PH_REL  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    CY_FETCH = 2'd0,
    CY_READ  = 2'd1,
    CY_WRITE = 2'd2
  } cyc_e;

  typedef struct packed {
    cyc_e            kind;
    logic [XB_W-1:0] pg;
    logic [XB_W-1:0] hi;
    logic [XB_W-1:0] lo;
    logic [XB_W-1:0] wd;
  } xreq_t;

endpackage

// File: rtl/xbus_arb.sv
module xbus_arb
  import xbus_pkg::*;
(
  input  logic              accept_ok,
  input  logic              fetch_req,
  input  logic [2*XB_W-1:0] fetch_addr,
  input  logic              data_req,
  input  logic              data_we,
  input  logic [3*XB_W-1:0] data_addr,
  input  logic [XB_W-1:0]   data_wdata,
  output logic              start,
  output xreq_t             req
);

  always_comb begin
    start = accept_ok && (fetch_req || data_req);
    if (fetch_req) begin
      req.kind = CY_FETCH;
      req.pg   = '0;
      req.hi   = fetch_addr[2*XB_W-1:XB_W];
      req.lo   = fetch_addr[XB_W-1:0];
      req.wd   = '0;
    end else begin
      req.kind = data_we ? CY_WRITE : CY_READ;
      req.pg   = data_addr[3*XB_W-1:2*XB_W];
      req.hi   = data_addr[2*XB_W-1:XB_W];
      req.lo   = data_addr[XB_W-1:0];
      req.wd   = data_wdata;
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_CLKS = 2,
  parameter int HOLD_CLKS = 1,
  parameter int STRB_CLKS = 3,
  parameter int REL_CLKS  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  xreq_t           req,
  input  logic [XB_W-1:0] p0_in,
  output logic            accept_ok,
  output phase_e          phase,
  output xreq_t           cur,
  output logic [XB_W-1:0] rdata,
  output logic            done
);

  localparam int MAX_AH = (ADDR_CLKS > HOLD_CLKS) ? ADDR_CLKS : HOLD_CLKS;
  localparam int MAX_SR = (STRB_CLKS > REL_CLKS) ? STRB_CLKS : REL_CLKS;
  localparam int MAXL   = (MAX_AH > MAX_SR) ? MAX_AH : MAX_SR;
  localparam int CNT_W  = (MAXL > 1) ? $clog2(MAXL) : 1;

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_CLKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CLKS - 1);
  localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STRB_CLKS - 1);
  localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(REL_CLKS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  xreq_t            cur_q;
  logic [XB_W-1:0]  rdata_q;
  logic             done_q, done_d;
  logic             cur_en, rd_en, last;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cur_en  = 1'b0;
    rd_en   = 1'b0;
    done_d  = 1'b0;
    last    = (cnt_q == '0);
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ADDR;
          cnt_d   = ADDR_LAST;
          cur_en  = 1'b1;
        end
      end
      PH_ADDR: begin
        if (last) begin
          phase_d = PH_HOLD;
          cnt_d   = HOLD_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (last) begin
          phase_d = PH_STRB;
          cnt_d   = STRB_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STRB: begin
        if (last) begin
          phase_d = PH_REL;
          cnt_d   = REL_LAST;
          rd_en   = (cur_q.kind != CY_WRITE);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_REL: begin
        if (last) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // captured request, loaded only at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_en) begin
      cur_q <= req;
    end
  end

  // returned byte, loaded on the last strobe clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= p0_in;
    end
  end

  assign accept_ok = (phase_q == PH_IDLE) && !done_q;
  assign phase     = phase_q;
  assign cur       = cur_q;
  assign rdata     = rdata_q;
  assign done      = done_q;

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
(
  input  phase_e          phase,
  input  xreq_t           cur,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic [XB_W-1:0] p0_out,
  output logic            p0_oe,
  output logic [XB_W-1:0] p2_out,
  output logic            p2_oe
);

  logic addr_ph, strb_ph, data_ph, is_wr;

  always_comb begin
    addr_ph = (phase == PH_ADDR) || (phase == PH_HOLD);
    strb_ph = (phase == PH_STRB);
    data_ph = (phase == PH_STRB) || (phase == PH_REL);
    is_wr   = (cur.kind == CY_WRITE);

    ale    = (phase == PH_ADDR);
    psen_n = !(strb_ph && (cur.kind == CY_FETCH));
    rd_n   = !(strb_ph && (cur.kind == CY_READ));
    wr_n   = !(strb_ph && is_wr);

    p0_oe  = addr_ph || (data_ph && is_wr);
    if (addr_ph) begin
      p0_out = cur.lo;
    end else if (data_ph && is_wr) begin
      p0_out = cur.wd;
    end else begin
      p0_out = '0;
    end

    p2_oe = (phase != PH_IDLE);
    if (phase == PH_IDLE) begin
      p2_out = '0;
    end else if (ale && (cur.kind != CY_FETCH)) begin
      p2_out = cur.pg;
    end else begin
      p2_out = cur.hi;
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_CLKS = 2,
  parameter int HOLD_CLKS = 1,
  parameter int STRB_CLKS = 3,
  parameter int REL_CLKS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [2*XB_W-1:0] fetch_addr,
  input  logic              data_req,
  input  logic              data_we,
  input  logic [3*XB_W-1:0] data_addr,
  input  logic [XB_W-1:0]   data_wdata,
  output logic              busy,
  output logic              fetch_done,
  output logic              data_done,
  output logic [XB_W-1:0]   rdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [XB_W-1:0]   p0_out,
  output logic              p0_oe,
  input  logic [XB_W-1:0]   p0_in,
  output logic [XB_W-1:0]   p2_out,
  output logic              p2_oe
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic   accept_ok, start, done;
  xreq_t  req, cur;
  phase_e phase;

  xbus_arb u_arb (
    .accept_ok (accept_ok),
    .fetch_req (fetch_req),
    .fetch_addr(fetch_addr),
    .data_req  (data_req),
    .data_we   (data_we),
    .data_addr (data_addr),
    .data_wdata(data_wdata),
    .start     (start),
    .req       (req)
  );

  xbus_seq #(
    .ADDR_CLKS(ADDR_CLKS),
    .HOLD_CLKS(HOLD_CLKS),
    .STRB_CLKS(STRB_CLKS),
    .REL_CLKS (REL_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .req      (req),
    .p0_in    (p0_in),
    .accept_ok(accept_ok),
    .phase    (phase),
    .cur      (cur),
    .rdata    (rdata),
    .done     (done)
  );

  xbus_pins u_pins (
    .phase (phase),
    .cur   (cur),
    .ale   (ale),
    .psen_n(psen_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .p0_out(p0_out),
    .p0_oe (p0_oe),
    .p2_out(p2_out),
    .p2_oe (p2_oe)
  );

  assign busy       = (phase != PH_IDLE);
  assign fetch_done = done && (cur.kind == CY_FETCH);
  assign data_done  = done && (cur.kind != CY_FETCH);

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       fetch_done,
  input logic       data_done,
  input logic       ale,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [7:0] p0_out,
  input logic       p0_oe,
  input logic [7:0] p2_out,
  input logic       p2_oe
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (psen_n && rd_n && wr_n && !ale && !p0_oe && !p2_oe));

  p_ale_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n && p0_oe));

  p_psen_p2_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n && $past(!psen_n)) |-> $stable(p2_out));

  p_wr_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(p0_out) && p0_oe));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done || data_done) |-> !busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done || data_done) |=> !(fetch_done || data_done));

  p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_done && data_done));

  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  p_oe_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(p0_oe && (!psen_n || !rd_n)));

endmodule

bind xbus_ctrl xbus_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .fetch_done(fetch_done),
  .data_done (data_done),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .p0_out    (p0_out),
  .p0_oe     (p0_oe),
  .p2_out    (p2_out),
  .p2_oe     (p2_oe)
);

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;

  localparam int TA  = 2;
  localparam int TH  = 1;
  localparam int TS  = 3;
  localparam int TR  = 2;
  localparam int TOT = TA + TH + TS + TR;

  logic        clk;
  logic        rst_n;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic        data_req;
  logic        data_we;
  logic [23:0] data_addr;
  logic [7:0]  data_wdata;
  logic        busy, fetch_done, data_done;
  logic [7:0]  rdata;
  logic        ale, psen_n, rd_n, wr_n;
  logic [7:0]  p0_out, p0_in, p2_out;
  logic        p0_oe, p2_oe;

  int tests;
  int fails;
  bit chk_on;

  xbus_ctrl #(
    .ADDR_CLKS(TA),
    .HOLD_CLKS(TH),
    .STRB_CLKS(TS),
    .REL_CLKS (TR)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .fetch_addr(fetch_addr),
    .data_req  (data_req),
    .data_we   (data_we),
    .data_addr (data_addr),
    .data_wdata(data_wdata),
    .busy      (busy),
    .fetch_done(fetch_done),
    .data_done (data_done),
    .rdata     (rdata),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .p0_out    (p0_out),
    .p0_oe     (p0_oe),
    .p0_in     (p0_in),
    .p2_out    (p2_out),
    .p2_oe     (p2_oe)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] code_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] dflt_byte(input logic [23:0] a);
    return a[7:0] + a[15:8] + a[23:16] + 8'h11;
  endfunction

  // ---------------- external memory stub with low and page latches
  logic [7:0] lat_lo, lat_pg;
  logic [7:0] stub_mem [logic [23:0]];

  always @(negedge clk) begin
    if (ale) begin
      lat_lo <= p0_out;
      lat_pg <= p2_out;
    end
    if (!wr_n) stub_mem[{lat_pg, p2_out, lat_lo}] = p0_out;
  end

  always_comb begin
    if (!psen_n) begin
      p0_in = code_byte({p2_out, lat_lo});
    end else if (!rd_n) begin
      if (stub_mem.exists({lat_pg, p2_out, lat_lo})) p0_in = stub_mem[{lat_pg, p2_out, lat_lo}];
      else p0_in = dflt_byte({lat_pg, p2_out, lat_lo});
    end else begin
      p0_in = 8'hEE;
    end
  end

  // ---------------- behavioural reference model
  int          m_t;
  int          m_kind;   // 0 fetch, 1 read, 2 write
  logic [23:0] m_addr;
  logic [7:0]  m_wd;
  logic [7:0]  m_rd;
  bit          m_dn;
  int          m_dk;
  logic [7:0]  shadow [logic [23:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t  = -1;
      m_dn = 0;
      m_rd = 8'h00;
      m_dk = 0;
    end else if (m_t >= 0) begin
      if (m_t == TA + TH + TS - 1) begin
        if (m_kind == 0) m_rd = code_byte(m_addr[15:0]);
        else if (m_kind == 1) m_rd = shadow.exists(m_addr) ? shadow[m_addr] : dflt_byte(m_addr);
        else shadow[m_addr] = m_wd;
      end
      if (m_t == TOT - 1) begin
        m_t  = -1;
        m_dn = 1;
        m_dk = m_kind;
      end else begin
        m_t = m_t + 1;
      end
    end else if (m_dn) begin
      m_dn = 0;
    end else if (fetch_req) begin
      m_kind = 0;
      m_addr = {8'h00, fetch_addr};
      m_wd   = 8'h00;
      m_t    = 0;
    end else if (data_req) begin
      m_kind = data_we ? 2 : 1;
      m_addr = data_addr;
      m_wd   = data_wdata;
      m_t    = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      automatic int ph = (m_t < 0) ? 0 : (m_t < TA) ? 1 : (m_t < TA + TH) ? 2 :
                         (m_t < TA + TH + TS) ? 3 : 4;
      automatic bit e_oe0 = (ph == 1) || (ph == 2) || (m_kind == 2 && ph >= 3);
      check("R2 ale", ale, ph == 1);
      check("R3 psen_n", psen_n, !(ph == 3 && m_kind == 0));
      check("R6 rd_n", rd_n, !(ph == 3 && m_kind == 1));
      check("R5 wr_n", wr_n, !(ph == 3 && m_kind == 2));
      check("R10 p0_oe", p0_oe, e_oe0);
      if (e_oe0) begin
        if (ph <= 2) check("R2 p0_out address", p0_out, m_addr[7:0]);
        else check("R5 p0_out write data", p0_out, m_wd);
      end
      check("R1 p2_oe", p2_oe, ph != 0);
      if (ph != 0) begin
        if (m_kind != 0 && ph == 1) check("R4 p2_out page", p2_out, m_addr[23:16]);
        else if (m_kind != 0) check("R4 p2_out high", p2_out, m_addr[15:8]);
        else check("R3 p2_out pc high", p2_out, m_addr[15:8]);
      end
      check("R8 busy", busy, ph != 0);
      check("R9 fetch_done", fetch_done, m_dn && m_dk == 0);
      check("R9 data_done", data_done, m_dn && m_dk != 0);
      if (m_dn && m_dk != 2) check(m_dk == 0 ? "R3 rdata" : "R6 rdata", rdata, m_rd);
      check("R10 strobe exclusive", $countones({!psen_n, !rd_n, !wr_n}) <= 1, 1);
      check("R10 oe vs strobe", p0_oe && (!psen_n || !rd_n), 0);
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!(fetch_done || data_done));
  endtask

  task automatic do_fetch(input logic [15:0] a);
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    wait_done();
    fetch_req = 1'b0;
  endtask

  task automatic do_data(input logic we, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    data_req   = 1'b1;
    data_we    = we;
    data_addr  = a;
    data_wdata = d;
    wait_done();
    data_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tests = 0; fails = 0; chk_on = 0;
    rst_n = 1'b0;
    fetch_req = 1'b0; fetch_addr = '0;
    data_req = 1'b0; data_we = 1'b0; data_addr = '0; data_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 ale", ale, 0);
    check("R1 strobes", {psen_n, rd_n, wr_n}, 3'b111);
    check("R1 oe", {p0_oe, p2_oe}, 2'b00);
    check("R1 done", {busy, fetch_done, data_done}, 3'b000);
    chk_on = 1;

    // R2 R3: fetches at boundary and mixed addresses
    do_fetch(16'h0000);
    do_fetch(16'hFFFF);
    do_fetch(16'h12A5);

    // R4 R5 R6: two pointers differing only in the page byte
    do_data(1'b1, 24'h012345, 8'hA1);
    do_data(1'b1, 24'h022345, 8'hB2);
    do_data(1'b0, 24'h012345, 8'h00);
    check("R4 page 1 read", rdata, 8'hA1);
    do_data(1'b0, 24'h022345, 8'h00);
    check("R4 page 2 read", rdata, 8'hB2);
    do_data(1'b0, 24'hFF00FF, 8'h00);
    do_data(1'b1, 24'h000000, 8'h5A);

    // R7: both requests on the same edge
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 16'h3C3C;
    data_req = 1'b1; data_we = 1'b0; data_addr = 24'h000000; data_wdata = 8'h00;
    wait_done();
    check("R7 fetch first", {fetch_done, data_done}, 2'b10);
    fetch_req = 1'b0;
    wait_done();
    check("R7 data second", {fetch_done, data_done}, 2'b01);
    check("R7 read value", rdata, 8'h5A);
    data_req = 1'b0;

    // R8: request inputs changed while busy are ignored until done
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 16'hBEEF;
    repeat (2) @(negedge clk);
    fetch_addr = 16'h0101;
    data_req = 1'b1; data_we = 1'b1; data_addr = 24'h7F8081; data_wdata = 8'hC3;
    wait_done();
    check("R8 captured fetch byte", rdata, code_byte(16'hBEEF));
    fetch_req = 1'b0;
    wait_done();
    check("R8 deferred write done", data_done, 1);
    data_req = 1'b0;
    do_data(1'b0, 24'h7F8081, 8'h00);
    check("R8 deferred write stored", rdata, 8'hC3);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule